// File: doc/BRIEF.md
# Two-Channel UART Interrupt Vector and Status Unit

This block gathers the interrupt sources of a two-channel serial port and enables them through a mask register. It raises a single request line while any enabled source is pending. Each channel has four source bits: transmitter ready, receiver ready, receiver error and a catch-all "other".

When the host runs an interrupt-acknowledge cycle, the unit places an 8-bit vector on its acknowledge output. It forms that vector in one of four programmable ways. It can give a constant that means "no vector". It can give a programmable base byte unchanged. It can give the base byte with the channel number spliced into bit 0. It can give the base byte with both an encoded interrupt type and the channel number spliced into its low bits. Software can read a status byte, shown either as the raw source state or filtered through the mask.

Registers are reached through a small synchronous strobe interface with a one-cycle read latency.

Top module: `uart_irq_vec_unit`

## Requirements
- R1: After reset the base-vector register (address 0) reads 0x0F, the enable mask (address 1) reads 0x00 and the configuration register (address 3) reads 0x00. Configuration bits [1:0] hold the vector mode and bit 2 enables masked status.
- R2: A write strobe stores `reg_wdata` into the register at `reg_addr` (addresses 0, 1 and 3). A read strobe returns the addressed register on `reg_rdata` one clock later. Address 2 ignores writes.
- R3: Source bits are laid out as {src_b, src_a}, with bit 0 = transmitter ready, bit 1 = receiver ready, bit 2 = receiver error and bit 3 = other within each channel nibble. With masked status off, a status read (address 2) returns this raw byte.
- R4: With masked status on, the status read returns the raw byte ANDed with the enable mask.
- R5: `irq` is high exactly when some source bit is set together with its mask bit, whatever the status mode.
- R6: Vector mode 00 gives 0xFF on `ack_vec`.
- R7: Vector mode 01 gives the base vector unchanged.
- R8: Vector mode 10 gives base[7:1] with bit 0 set to the channel code (0 = channel A, 1 = channel B).
- R9: Vector mode 11 gives base[7:3], then a 2-bit type in bits 2:1, then the channel code in bit 0. The type codes are 11 for receiver error, 10 for receiver ready, 01 for transmitter and 00 for other.
- R10: The reported source is the highest-priority pending, enabled one. The order is receiver error, then receiver ready, then transmitter, then other, and channel A comes before channel B at each level.
- R11: `ack_vec` is captured on the first clock edge at which `iack` is seen high. `ack_valid` rises with it, and the vector stays unchanged until `iack` drops. `ack_valid` falls on the edge at which `iack` is seen low.
- R12: If no enabled source is pending at capture, the type and channel fields are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| src_a | input | 4 | Channel A source bits |
| src_b | input | 4 | Channel B source bits |
| iack | input | 1 | Interrupt-acknowledge strobe (level) |
| irq | output | 1 | Interrupt request |
| ack_vec | output | 8 | Acknowledge vector |
| ack_valid | output | 1 | Acknowledge vector held |

## Verification
Assertions check on every cycle the parts that are fixed by state alone. The request line must match the masked sources. The priority grant must be at most one-hot and must point at an enabled, pending source. The captured vector must hold steady for the whole acknowledge, and the acknowledge flag must follow the strobe. The no-vector constant is also checked at capture. The contents of the vector in the other three modes, the priority ordering between competing sources and the two status readout modes need known register settings. Only the bench's directed and random scenarios, checked against its own model, show those.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NCH  = 2;
  localparam int NSRC = 4;
  localparam int SW   = NCH * NSRC;
  localparam int DW   = 8;

  // source bit positions inside a channel nibble
  localparam int S_TX  = 0;
  localparam int S_RX  = 1;
  localparam int S_ERR = 2;
  localparam int S_OTH = 3;

  typedef enum logic [1:0] {
    VM_NONE = 2'b00,
    VM_FULL = 2'b01,
    VM_CHAN = 2'b10,
    VM_TYPE = 2'b11
  } vmode_e;

  typedef struct packed {
    logic       smask;
    vmode_e     mode;
  } cfg_t;

  // priority level (0 = highest) to source position
  function automatic int lvl_src(input int lvl);
    case (lvl)
      0:       return S_ERR;
      1:       return S_RX;
      2:       return S_TX;
      default: return S_OTH;
    endcase
  endfunction

  function automatic logic [1:0] type_code(input int src);
    case (src)
      S_ERR:   return 2'b11;
      S_RX:    return 2'b10;
      S_TX:    return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [DW-1:0] build_vec(input vmode_e m, input logic [DW-1:0] base,
                                              input logic [1:0] tcode, input logic ch);
    case (m)
      VM_NONE: return '1;
      VM_FULL: return base;
      VM_CHAN: return {base[DW-1:1], ch};
      default: return {base[DW-1:3], tcode, ch};
    endcase
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_vec_pkg::*;
#(
  parameter logic [DW-1:0] BASE_RST = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] src,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] base_q,
  output logic [SW-1:0] mask_q,
  output cfg_t          cfg_q
);
  localparam logic [1:0] A_BASE = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CFG  = 2'd3;

  logic [SW-1:0] stat_view;
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      mask_q <= '0;
      cfg_q  <= '{smask: 1'b0, mode: VM_NONE};
    end else if (wr) begin
      case (addr)
        A_BASE:  base_q <= wdata;
        A_MASK:  mask_q <= wdata[SW-1:0];
        A_CFG:   cfg_q  <= '{smask: wdata[2], mode: vmode_e'(wdata[1:0])};
        default: ;
      endcase
    end
  end

  assign stat_view = cfg_q.smask ? (src & mask_q) : src;

  always_comb begin
    case (addr)
      A_BASE:  rd_mux = base_q;
      A_MASK:  rd_mux = DW'(mask_q);
      A_STAT:  rd_mux = DW'(stat_view);
      default: rd_mux = DW'({cfg_q.smask, cfg_q.mode});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_vec_pkg::*;
(
  input  logic [SW-1:0] pend,
  output logic          any,
  output logic [SW-1:0] grant,
  output logic          ch,
  output logic [1:0]    tcode
);
  always_comb begin
    grant = '0;
    ch    = 1'b0;
    tcode = 2'b00;
    any   = 1'b0;
    for (int lv = 0; lv < NSRC; lv++) begin
      for (int c = 0; c < NCH; c++) begin
        if (!any && pend[c*NSRC + lvl_src(lv)]) begin
          any   = 1'b1;
          grant[c*NSRC + lvl_src(lv)] = 1'b1;
          ch    = c[0];
          tcode = type_code(lvl_src(lv));
        end
      end
    end
  end
endmodule

// File: rtl/irq_ack.sv
module irq_ack
  import irq_vec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iack,
  input  logic [DW-1:0] vec_next,
  output logic          active,
  output logic [DW-1:0] vec_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      vec_hold <= '0;
    end else if (!iack) begin
      active   <= 1'b0;
    end else if (!active) begin
      active   <= 1'b1;
      vec_hold <= vec_next;
    end
  end
endmodule

// File: rtl/uart_irq_vec_unit.sv
module uart_irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter logic [7:0] BASE_RST = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [3:0] src_a,
  input  logic [3:0] src_b,
  input  logic       iack,
  output logic       irq,
  output logic [7:0] ack_vec,
  output logic       ack_valid
);
  logic [SW-1:0] src_all;
  logic [SW-1:0] mask_q;
  logic [DW-1:0] base_q;
  cfg_t          cfg_q;
  logic [SW-1:0] pend_en;
  logic [SW-1:0] grant;
  logic          win_any;
  logic          win_ch;
  logic [1:0]    win_type;
  logic [DW-1:0] vec_next;

  assign src_all = {src_b, src_a};

  irq_regs #(.BASE_RST(BASE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .src(src_all), .rdata(reg_rdata),
    .base_q(base_q), .mask_q(mask_q), .cfg_q(cfg_q)
  );

  assign pend_en = src_all & mask_q;

  irq_prio u_prio (
    .pend(pend_en), .any(win_any), .grant(grant), .ch(win_ch), .tcode(win_type)
  );

  assign irq      = win_any;
  assign vec_next = build_vec(cfg_q.mode, base_q, win_type, win_ch);

  irq_ack u_ack (
    .clk(clk), .rst_n(rst_n), .iack(iack), .vec_next(vec_next),
    .active(ack_valid), .vec_hold(ack_vec)
  );
endmodule

// File: rtl/irq_vec_checker.sv
module irq_vec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src_a,
  input logic [3:0] src_b,
  input logic [7:0] mask_q,
  input logic [1:0] mode,
  input logic [7:0] grant,
  input logic       iack,
  input logic       irq,
  input logic [7:0] ack_vec,
  input logic       ack_valid
);
  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (({src_b, src_a} & mask_q) != 8'h00));

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 8'h00) |-> ((grant & mask_q & {src_b, src_a}) == grant));

  p_ack_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack) |=> ack_valid);

  p_ack_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> !ack_valid);

  p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && $past(ack_valid)) |-> $stable(ack_vec));

  p_none_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_valid) && $past(mode) == 2'b00) |-> ack_vec == 8'hFF);
endmodule

bind uart_irq_vec_unit irq_vec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .mask_q(mask_q),
  .mode(cfg_q.mode), .grant(grant), .iack(iack), .irq(irq),
  .ack_vec(ack_vec), .ack_valid(ack_valid)
);

// File: tb/uart_irq_vec_unit_bench.sv
module uart_irq_vec_unit_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, iack = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [3:0] src_a = 0, src_b = 0;
  logic irq, ack_valid;
  logic [7:0] ack_vec;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  uart_irq_vec_unit u_uart_irq_vec_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_a(src_a), .src_b(src_b),
    .iack(iack), .irq(irq), .ack_vec(ack_vec), .ack_valid(ack_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // model: scan sources in priority order, spell out the vector
  function automatic logic [7:0] model_vec(input logic [1:0] m, input logic [7:0] b,
                                           input logic [7:0] en);
    logic [1:0] ty = 2'b00;
    logic ch = 1'b0;
    bit hit = 0;
    int order [8] = '{2, 6, 1, 5, 0, 4, 3, 7};
    for (int k = 0; k < 8; k++)
      if (!hit && en[order[k]]) begin
        hit = 1;
        ch = (order[k] >= 4);
        case (order[k] % 4)
          2: ty = 2'b11;
          1: ty = 2'b10;
          0: ty = 2'b01;
          default: ty = 2'b00;
        endcase
      end
    if (m == 2'b00) return 8'hFF;
    if (m == 2'b01) return b;
    if (m == 2'b10) return {b[7:1], ch};
    return {b[7:3], ty, ch};
  endfunction

  task automatic ack_run(input string req, input logic [7:0] exp);
    logic [7:0] first;
    @(negedge clk); iack = 1;
    @(negedge clk);
    chk("R11 valid rise", {7'b0, ack_valid}, 8'h01);
    chk(req, ack_vec, exp);
    first = ack_vec;
    src_a = ~src_a; src_b = ~src_b;
    @(negedge clk); @(negedge clk);
    chk("R11 vector held", ack_vec, first);
    iack = 0;
    @(negedge clk);
    chk("R11 valid fall", {7'b0, ack_valid}, 8'h00);
    src_a = ~src_a; src_b = ~src_b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, d); chk("R1 base", d, 8'h0F);
    rd(1, d); chk("R1 mask", d, 8'h00);
    rd(3, d); chk("R1 cfg", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    // R2 write/read, status ignores writes
    wr(0, 8'hA5); rd(0, d); chk("R2 base", d, 8'hA5);
    wr(3, 8'h06); rd(3, d); chk("R2 cfg", d, 8'h06);
    wr(3, 8'h00);
    src_a = 4'h0; src_b = 4'h0;
    wr(2, 8'hFF); rd(2, d); chk("R2 status write ignored", d, 8'h00);
    // R3 / R4
    src_a = 4'b0101; src_b = 4'b1010;
    wr(1, 8'h0F);
    rd(2, d); chk("R3 raw status", d, 8'hA5);
    wr(3, 8'h04);
    rd(2, d); chk("R4 masked status", d, 8'h05);
    // R5 irq independent of status mode
    @(negedge clk); chk("R5 irq", {7'b0, irq}, 8'h01);
    wr(1, 8'h00); @(negedge clk); chk("R5 irq masked off", {7'b0, irq}, 8'h00);
    // R6..R9 and R10: A error vs B error -> A wins
    src_a = 4'b0100; src_b = 4'b0100; wr(1, 8'hFF); wr(0, 8'hF8);
    wr(3, 8'h00); ack_run("R6 mode none", 8'hFF);
    wr(3, 8'h01); ack_run("R7 mode full", 8'hF8);
    src_a = 4'b0000; src_b = 4'b0010;
    wr(3, 8'h02); ack_run("R8 mode chan B", 8'hF9);
    wr(3, 8'h03); ack_run("R9 mode type rx B", 8'hFD);
    src_a = 4'b0001; src_b = 4'b0010;
    ack_run("R10 rx B over tx A", 8'hFD);
    src_a = 4'b1000; src_b = 4'b0000;
    ack_run("R9 other A", 8'hF8);
    src_a = 4'b1111; src_b = 4'b1111; wr(1, 8'h00);
    ack_run("R12 none enabled", 8'hF8);
    // random
    for (int i = 0; i < 150; i++) begin
      logic [7:0] b = 8'($urandom), mk = 8'($urandom), cf = 8'($urandom & 7);
      src_a = 4'($urandom); src_b = 4'($urandom);
      wr(0, b); wr(1, mk); wr(3, cf);
      rd(2, d);
      chk("R3 R4 random status", d, cf[2] ? ({src_b, src_a} & mk) : {src_b, src_a});
      chk("R5 random irq", {7'b0, irq}, {7'b0, |({src_b, src_a} & mk)});
      ack_run("R10 random vector", model_vec(cf[1:0], b, {src_b, src_a} & mk));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule